// File: doc/BRIEF.md
# Auto-Stepping Memory Pointer Unit

This unit gives a small 16-bit signal processor a bank of external-memory pointers that step by themselves. Software loads a 32-bit control word through one register as two 16-bit halves: first the address half, then the mode half. A "blind" access then copies the control word into a pointer. A blind access is a pointer access that carries no data; the instruction decoder marks it with a flag. A blind read fills the pointer's read slot and a blind write fills its write slot.

Later reads and writes through a pointer decode that slot's mode half. The decode gives a memory region (ROM, DRAM or internal RAM), a word address and byte-nibble enables on a simple synchronous request port. The slot's address then moves by the programmed step. After each data access the control register holds the updated slot, so software can read back where the pointer now points.

Top module: `mptr_unit`

## Requirements
- R1: The control register alternates between an address phase and a mode phase. Every control read or write that is not in the same cycle as a pointer access moves it to the other phase. An access in the mode phase (read or write) leaves a programming request pending and returns to the address phase.
- R2: A control read returns the address half in the address phase and the mode half in the mode phase. After a pointer data access, the control register holds that pointer's slot (address half and mode half) as updated by the step.
- R3: While a request is pending, a blind read access to pointer n loads n's read slot and a blind write access loads n's write slot. A non-blind access only cancels the request. Neither kind issues a memory request, and a cancelled request leaves the slots unchanged.
- R4: Mode bits [13:11] select a step of 0, 1, 2, 4, 8, 16, 32 or 128 words for codes 0 to 7. Mode bit 15 set subtracts the step instead of adding it. The address wraps modulo 2^16.
- R5: A read slot whose mode masked with 0xFFF0 equals 0x0800 reads ROM (region code 1). The address is {mode[3:0], addr[15:0]} and the pointer always advances by +1.
- R6: A read slot whose mode masked with 0x47FF equals 0x0018 reads DRAM (region code 2). Read data appears on acc_rdata with acc_rvalid one cycle after the access.
- R7: A write slot whose mode masked with 0x43FF equals 0x0018 writes DRAM. When mode bit 10 is set, only nibbles of the write data that are non-zero are enabled (mem_nib_en bit k covers data bits [4k+3:4k]). Otherwise all four nibbles are enabled.
- R8: A write slot whose mode masked with 0xFBFF equals 0x4018 writes DRAM with a cell stride: +31 from an odd address and +1 from an even one. Mode bit 10 gives nibble masking as in R7. This match takes priority over R7.
- R9: A write slot whose mode masked with 0x47FF equals 0x001C writes internal RAM (region code 3) at addr[9:0] and steps per R4. iram_bad is raised when addr[15:10] is not 6'b100000.
- R10: Any other mode issues no memory request (region code 0) and leaves the pointer unchanged. A read through such a slot returns 0 with acc_rvalid.
- R11: A pointer access made while only the address half has been written still executes. It returns the control register to the address phase and pulses seq_err for exactly one cycle, in the cycle after the access.
- R12: After reset the control register reads 0 in the address phase with nothing pending, all slots are zero, and no request, error or read-valid is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Control register write strobe |
| cfg_rd_i | input | 1 | Control register read strobe |
| cfg_wdata_i | input | 16 | Control write data |
| cfg_rdata_o | output | 16 | Control read data (half chosen by phase) |
| acc_valid_i | input | 1 | Pointer access strobe |
| acc_ptr_i | input | PW | Pointer index |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_blind_i | input | 1 | Access carries no data (programming form) |
| acc_wdata_i | input | 16 | Write data for a pointer write |
| acc_rvalid_o | output | 1 | Read result valid (one cycle after access) |
| acc_rdata_o | output | 16 | Read result |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_region_o | output | 2 | 0 none, 1 ROM, 2 DRAM, 3 internal RAM |
| mem_addr_o | output | 20 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_nib_en_o | output | 4 | Nibble write enables |
| mem_rdata_i | input | 16 | Read data, one cycle after request |
| iram_bad_o | output | 1 | Internal RAM address outside its window |
| seq_err_o | output | 1 | Access with only the address half set |

## Verification
A vector table drives every step code through DRAM reads, covering both directions and wrap below zero. It also runs ROM reads that include the top-bank wrap, plain and overwrite DRAM writes, cell strides from odd and even addresses, internal RAM writes inside and outside the window, and unrecognised modes on both sides. Each row checks the request fields, then reads the control register back to separate an error in the step from an error in the address. It also spreads over all pointers, so a slot-select fault shows up. Directed sequences tell apart a cancelled set from a programming one, and a normal access from an address-only access.

// File: rtl/mptr_pkg.sv
package mptr_pkg;

    localparam int DW   = 16;
    localparam int MAW  = 20;
    localparam int NIBS = DW / 4;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_ROM  = 2'd1,
        RG_DRAM = 2'd2,
        RG_IRAM = 2'd3
    } region_e;

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_MODE = 1'b1
    } phase_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] mode;
    } ptr_word_t;

    function automatic logic [DW-1:0] step_amt(input logic [2:0] code);
        logic [DW-1:0] s;
        case (code)
            3'd0:    s = '0;
            3'd7:    s = DW'(128);
            default: s = DW'(1) << (code - 3'd1);
        endcase
        return s;
    endfunction

    function automatic logic is_cell(input logic [DW-1:0] mode, input logic wr);
        return wr && ((mode & 16'hFBFF) == 16'h4018);
    endfunction

    function automatic region_e classify(input logic [DW-1:0] mode, input logic wr);
        region_e r;
        r = RG_NONE;
        if (!wr) begin
            if ((mode & 16'hFFF0) == 16'h0800)      r = RG_ROM;
            else if ((mode & 16'h47FF) == 16'h0018) r = RG_DRAM;
        end else begin
            if (is_cell(mode, wr))                  r = RG_DRAM;
            else if ((mode & 16'h43FF) == 16'h0018) r = RG_DRAM;
            else if ((mode & 16'h47FF) == 16'h001C) r = RG_IRAM;
        end
        return r;
    endfunction

endpackage

// File: rtl/mptr_ctl.sv
module mptr_ctl
    import mptr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr_i,
    input  logic          cfg_rd_i,
    input  logic [DW-1:0] cfg_wdata_i,
    input  logic          acc_take_i,
    input  logic          load_en_i,
    input  ptr_word_t     load_val_i,
    output logic [DW-1:0] cfg_rdata_o,
    output logic          pend_o,
    output phase_e        phase_o,
    output ptr_word_t     cr_o
);
    phase_e    phase_q;
    logic      pend_q;
    ptr_word_t cr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_ADDR;
            pend_q  <= 1'b0;
            cr_q    <= '0;
        end else if (acc_take_i) begin
            phase_q <= PH_ADDR;
            pend_q  <= 1'b0;
            if (load_en_i) cr_q <= load_val_i;
        end else if (cfg_wr_i || cfg_rd_i) begin
            if (phase_q == PH_MODE) begin
                if (cfg_wr_i) cr_q.mode <= cfg_wdata_i;
                pend_q  <= 1'b1;
                phase_q <= PH_ADDR;
            end else begin
                if (cfg_wr_i) cr_q.addr <= cfg_wdata_i;
                phase_q <= PH_MODE;
            end
        end
    end

    assign cfg_rdata_o = (phase_q == PH_MODE) ? cr_q.mode : cr_q.addr;
    assign pend_o      = pend_q;
    assign phase_o     = phase_q;
    assign cr_o        = cr_q;

    assert_mode_arms_R1: assert property (@(posedge clk) disable iff (rst)
        ((cfg_wr_i || cfg_rd_i) && !acc_take_i && phase_q == PH_MODE)
        |=> (pend_q && phase_q == PH_ADDR));

    assert_addr_toggles_R1: assert property (@(posedge clk) disable iff (rst)
        ((cfg_wr_i || cfg_rd_i) && !acc_take_i && phase_q == PH_ADDR)
        |=> (phase_q == PH_MODE));

    assert_take_clears_R3: assert property (@(posedge clk) disable iff (rst)
        acc_take_i |=> (!pend_q && phase_q == PH_ADDR));

endmodule

// File: rtl/mptr_slot_bank.sv
module mptr_slot_bank
    import mptr_pkg::*;
#(
    parameter int NPTR = 5,
    parameter int PW   = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we_i,
    input  logic [PW-1:0]         sel_i,
    input  logic                  is_wr_i,
    input  ptr_word_t             wval_i,
    output ptr_word_t [NPTR-1:0]  rd_o,
    output ptr_word_t [NPTR-1:0]  wr_o
);
    for (genvar i = 0; i < NPTR; i++) begin : g_slot
        ptr_word_t rd_q, wr_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '0;
                wr_q <= '0;
            end else if (we_i && (int'(sel_i) == i)) begin
                if (is_wr_i) wr_q <= wval_i;
                else         rd_q <= wval_i;
            end
        end
        assign rd_o[i] = rd_q;
        assign wr_o[i] = wr_q;
    end

endmodule

// File: rtl/mptr_agu.sv
module mptr_agu
    import mptr_pkg::*;
(
    input  ptr_word_t        slot_i,
    input  logic             is_wr_i,
    input  logic [DW-1:0]    wdata_i,
    output region_e          region_o,
    output logic [MAW-1:0]   addr_o,
    output logic [NIBS-1:0]  nib_o,
    output ptr_word_t        next_o,
    output logic             iram_bad_o
);
    logic [NIBS-1:0] nz;
    logic [DW-1:0]   step, stepped;
    logic            ovw;

    for (genvar g = 0; g < NIBS; g++) begin : g_nib
        assign nz[g] = |wdata_i[4*g +: 4];
    end

    always_comb begin
        region_o   = classify(slot_i.mode, is_wr_i);
        step       = step_amt(slot_i.mode[13:11]);
        stepped    = slot_i.mode[15] ? (slot_i.addr - step) : (slot_i.addr + step);
        ovw        = slot_i.mode[10];
        next_o     = slot_i;
        addr_o     = MAW'(slot_i.addr);
        nib_o      = '0;
        iram_bad_o = 1'b0;
        case (region_o)
            RG_ROM: begin
                addr_o      = {slot_i.mode[3:0], slot_i.addr};
                next_o.addr = slot_i.addr + DW'(1);
            end
            RG_DRAM: begin
                if (is_cell(slot_i.mode, is_wr_i))
                    next_o.addr = slot_i.addr + (slot_i.addr[0] ? DW'(31) : DW'(1));
                else
                    next_o.addr = stepped;
                if (is_wr_i) nib_o = ovw ? nz : '1;
            end
            RG_IRAM: begin
                addr_o      = MAW'(slot_i.addr[9:0]);
                iram_bad_o  = (slot_i.addr[15:10] != 6'b100000);
                next_o.addr = stepped;
                nib_o       = '1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mptr_unit.sv
module mptr_unit
    import mptr_pkg::*;
#(
    parameter  int NPTR = 5,
    localparam int PW   = (NPTR > 1) ? $clog2(NPTR) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr_i,
    input  logic          cfg_rd_i,
    input  logic [15:0]   cfg_wdata_i,
    output logic [15:0]   cfg_rdata_o,
    input  logic          acc_valid_i,
    input  logic [PW-1:0] acc_ptr_i,
    input  logic          acc_write_i,
    input  logic          acc_blind_i,
    input  logic [15:0]   acc_wdata_i,
    output logic          acc_rvalid_o,
    output logic [15:0]   acc_rdata_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [1:0]    mem_region_o,
    output logic [19:0]   mem_addr_o,
    output logic [15:0]   mem_wdata_o,
    output logic [3:0]    mem_nib_en_o,
    input  logic [15:0]   mem_rdata_i,
    output logic          iram_bad_o,
    output logic          seq_err_o
);
    logic                 acc_ok, pend, prog, normal, hit;
    phase_e               phase;
    ptr_word_t            cr, cur, nxt, wval;
    ptr_word_t [NPTR-1:0] rd_arr, wr_arr;
    region_e              region;
    logic [MAW-1:0]       a20;
    logic [NIBS-1:0]      nib;
    logic                 bad;
    logic                 err_q, rv_q, hit_q;

    assign acc_ok = acc_valid_i && (int'(acc_ptr_i) < NPTR);
    assign cur    = acc_ok ? (acc_write_i ? wr_arr[acc_ptr_i] : rd_arr[acc_ptr_i]) : '0;
    assign prog   = acc_ok && pend && acc_blind_i;
    assign normal = acc_ok && !pend;
    assign hit    = normal && (region != RG_NONE);
    assign wval   = prog ? cr : nxt;

    mptr_ctl u_ctl (
        .clk(clk), .rst(rst),
        .cfg_wr_i(cfg_wr_i), .cfg_rd_i(cfg_rd_i), .cfg_wdata_i(cfg_wdata_i),
        .acc_take_i(acc_ok), .load_en_i(normal), .load_val_i(hit ? nxt : cur),
        .cfg_rdata_o(cfg_rdata_o), .pend_o(pend), .phase_o(phase), .cr_o(cr)
    );

    mptr_slot_bank #(.NPTR(NPTR), .PW(PW)) u_bank (
        .clk(clk), .rst(rst),
        .we_i(prog || hit), .sel_i(acc_ptr_i), .is_wr_i(acc_write_i),
        .wval_i(wval), .rd_o(rd_arr), .wr_o(wr_arr)
    );

    mptr_agu u_agu (
        .slot_i(cur), .is_wr_i(acc_write_i), .wdata_i(acc_wdata_i),
        .region_o(region), .addr_o(a20), .nib_o(nib), .next_o(nxt),
        .iram_bad_o(bad)
    );

    assign mem_req_o    = hit;
    assign mem_we_o     = hit && acc_write_i;
    assign mem_region_o = hit ? region : RG_NONE;
    assign mem_addr_o   = a20;
    assign mem_wdata_o  = acc_wdata_i;
    assign mem_nib_en_o = mem_we_o ? nib : '0;
    assign iram_bad_o   = hit && bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            rv_q  <= 1'b0;
            hit_q <= 1'b0;
        end else begin
            err_q <= normal && (phase == PH_MODE);
            rv_q  <= normal && !acc_write_i;
            hit_q <= hit && !acc_write_i;
        end
    end

    assign seq_err_o    = err_q;
    assign acc_rvalid_o = rv_q;
    assign acc_rdata_o  = hit_q ? mem_rdata_i : '0;

    assert_prog_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid_i && pend) |-> !mem_req_o);

    assert_rom_readonly_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (mem_region_o != 2'd1));

    assert_err_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        seq_err_o |=> !seq_err_o);

    assert_rvalid_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        acc_rvalid_o |-> $past(acc_valid_i && !acc_write_i));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid_i |-> (!mem_req_o && !iram_bad_o));

endmodule

// File: tb/mptr_unit_tb.sv
module mptr_unit_tb_top;
    import mptr_pkg::*;

    typedef struct packed {
        logic [15:0] mode;
        logic [15:0] addr;
        logic        wr;
        logic [15:0] wdata;
        logic [1:0]  rg;
        logic [19:0] a20;
        logic [15:0] nxt;
        logic [3:0]  nib;
        logic        bad;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [0:NV-1] = '{
        '{16'h0803, 16'h1234, 1'b0, 16'h0000, 2'd1, 20'h31234, 16'h1235, 4'h0, 1'b0},
        '{16'h080F, 16'hFFFF, 1'b0, 16'h0000, 2'd1, 20'hFFFFF, 16'h0000, 4'h0, 1'b0},
        '{16'h0018, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0100, 4'h0, 1'b0},
        '{16'h0818, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0101, 4'h0, 1'b0},
        '{16'h1018, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0102, 4'h0, 1'b0},
        '{16'h1818, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0104, 4'h0, 1'b0},
        '{16'h2018, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0108, 4'h0, 1'b0},
        '{16'h2818, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0110, 4'h0, 1'b0},
        '{16'h3018, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0120, 4'h0, 1'b0},
        '{16'h3818, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h0180, 4'h0, 1'b0},
        '{16'hA818, 16'h0100, 1'b0, 16'h0000, 2'd2, 20'h00100, 16'h00F0, 4'h0, 1'b0},
        '{16'hB818, 16'h0040, 1'b0, 16'h0000, 2'd2, 20'h00040, 16'hFFC0, 4'h0, 1'b0},
        '{16'h0818, 16'h2000, 1'b1, 16'h1357, 2'd2, 20'h02000, 16'h2001, 4'hF, 1'b0},
        '{16'h0C18, 16'h2000, 1'b1, 16'h0A0B, 2'd2, 20'h02000, 16'h2001, 4'h5, 1'b0},
        '{16'h4018, 16'h0003, 1'b1, 16'h1357, 2'd2, 20'h00003, 16'h0022, 4'hF, 1'b0},
        '{16'h4018, 16'h0004, 1'b1, 16'h1357, 2'd2, 20'h00004, 16'h0005, 4'hF, 1'b0},
        '{16'h081C, 16'h8005, 1'b1, 16'h1357, 2'd3, 20'h00005, 16'h8006, 4'hF, 1'b0},
        '{16'h101C, 16'h9001, 1'b1, 16'h1357, 2'd3, 20'h00001, 16'h9003, 4'hF, 1'b1},
        '{16'h0019, 16'h0100, 1'b0, 16'h0000, 2'd0, 20'h00000, 16'h0100, 4'h0, 1'b0},
        '{16'h0800, 16'h0100, 1'b1, 16'h1357, 2'd0, 20'h00000, 16'h0100, 4'h0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_blind = 1'b0;
    logic [2:0]  acc_ptr = '0;
    logic [15:0] acc_wdata = '0;
    logic        acc_rvalid;
    logic [15:0] acc_rdata;
    logic        mem_req, mem_we, iram_bad, seq_err;
    logic [1:0]  mem_region;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [3:0]  mem_nib_en;
    logic [15:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic        s_req, s_we, s_bad, s_rv, s_err;
    logic [1:0]  s_rg;
    logic [19:0] s_a20;
    logic [3:0]  s_nib;
    logic [15:0] s_rd, s_cfg;

    always #4 clk = ~clk;

    mptr_unit dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr_i(cfg_wr), .cfg_rd_i(cfg_rd), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .acc_valid_i(acc_valid), .acc_ptr_i(acc_ptr), .acc_write_i(acc_write),
        .acc_blind_i(acc_blind), .acc_wdata_i(acc_wdata),
        .acc_rvalid_o(acc_rvalid), .acc_rdata_o(acc_rdata),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_region_o(mem_region),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_nib_en_o(mem_nib_en),
        .mem_rdata_i(mem_rdata), .iram_bad_o(iram_bad), .seq_err_o(seq_err)
    );

    function automatic logic [15:0] mem_model(input logic [19:0] a, input logic [1:0] rg);
        return a[15:0] ^ 16'h5A00 ^ {14'h0, rg};
    endfunction

    always @(posedge clk)
        if (mem_req && !mem_we) mem_rdata <= mem_model(mem_addr, mem_region);

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read();
        @(negedge clk);
        cfg_rd = 1'b1;
        #1 s_cfg = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    task automatic access(input logic [2:0] p, input logic w, input logic b, input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_ptr = p; acc_write = w; acc_blind = b; acc_wdata = d;
        #1;
        s_req = mem_req; s_we = mem_we; s_rg = mem_region; s_a20 = mem_addr;
        s_nib = mem_nib_en; s_bad = iram_bad;
        @(negedge clk);
        acc_valid = 1'b0; acc_blind = 1'b0;
        s_rv = acc_rvalid; s_rd = acc_rdata; s_err = seq_err;
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.rg == 2'd1)              return "R5 rom";
        if (v.rg == 2'd0)              return "R10 unknown";
        if (v.rg == 2'd3)              return "R9 iram";
        if (v.wr && v.mode[14])        return "R8 cell";
        if (v.wr)                      return "R7 dram-wr";
        return "R6 dram-rd";
    endfunction

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check(cfg_rdata, 16'h0, "R12 cfg_rdata after reset");
        check({mem_req, seq_err, acc_rvalid}, 3'b000, "R12 idle outputs");
        access(3'd1, 1'b0, 1'b0, 16'h0);
        check(s_req, 1'b0, "R12 zero slot issues no request");
        check({s_rv, s_rd}, {1'b1, 16'h0}, "R12 zero slot read");

        // R1 / R2: phase alternation and half selection
        cfg_write(16'h1111);
        cfg_write(16'h2222);
        cfg_read(); check(s_cfg, 16'h1111, "R2 address half");
        cfg_read(); check(s_cfg, 16'h2222, "R2 mode half");
        cfg_read(); check(s_cfg, 16'h1111, "R1 wrap to address phase");
        access(3'd0, 1'b0, 1'b0, 16'h0);
        check(s_req, 1'b0, "R3 non-blind cancel issues no request");

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VEC[i];
            automatic logic [2:0] p = 3'(i % 5);
            cfg_write(v.addr);
            cfg_write(v.mode);
            access(p, v.wr, 1'b1, 16'h0);
            check(s_req, 1'b0, "R3 blind programming issues no request");
            access(p, v.wr, 1'b0, v.wdata);
            check(s_req, (v.rg != 2'd0), tag_of(v));
            check(s_rg, v.rg, tag_of(v));
            check(s_err, 1'b0, "R11 no error on complete set");
            if (v.rg != 2'd0) begin
                check(s_a20, v.a20, tag_of(v));
                check(s_we, v.wr, tag_of(v));
                check(s_nib, v.nib, tag_of(v));
                check(s_bad, v.bad, tag_of(v));
            end
            if (!v.wr) begin
                check({s_rv, s_rd}, {1'b1, (v.rg != 2'd0) ? mem_model(v.a20, v.rg) : 16'h0},
                      tag_of(v));
            end
            cfg_read(); check(s_cfg, v.nxt, "R4 stepped address read back (R2)");
            cfg_read(); check(s_cfg, v.mode, "R2 mode half kept");
        end

        // R3: cancel leaves slot untouched
        cfg_write(16'h0500);
        cfg_write(16'h0800);
        access(3'd2, 1'b0, 1'b1, 16'h0);
        cfg_write(16'h7777);
        cfg_write(16'h0818);
        access(3'd2, 1'b0, 1'b0, 16'h0);
        check({s_req, s_err}, 2'b00, "R3 non-blind cancel");
        access(3'd2, 1'b0, 1'b0, 16'h0);
        check(s_a20, 20'h00500, "R3 slot unchanged by cancel");
        check(s_rd, mem_model(20'h00500, 2'd1), "R5 rom data");

        // R11: address-only access
        cfg_write(16'h4444);
        access(3'd2, 1'b0, 1'b0, 16'h0);
        check(s_err, 1'b1, "R11 seq_err raised");
        check(s_a20, 20'h00501, "R11 access still executes");
        @(negedge clk);
        check(seq_err, 1'b0, "R11 seq_err lasts one cycle");
        cfg_read(); check(s_cfg, 16'h0502, "R11 phase back to address, pointer stepped");
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule